// File: doc/BRIEF.md
# Instruction Byte Sequencer

This block sits behind a bus-cycle classifier. The classifier emits one event each time a bus cycle finishes. The event carries the cycle kind and the byte seen on the data bus. The sequencer splits this event stream into instructions. It gathers the prefix bytes, the opcode, a displacement (before or after the opcode), an 8- or 16-bit immediate, and the read and write operand bytes. It then presents each of these as a field of its own.

The opcode tables are not part of the block. When the sequencer holds an opcode, it drives the prefix and opcode on a lookup port. An external table answers in the same cycle with the following attributes:
- a hit flag
- byte counts for displacement, immediate, read operand and write operand
- a repeat flag
- a flag that gives the write operand's byte order

Each byte is interpreted when the next event arrives, and the kind of that next event picks the branch. A byte sequence that does not fit the expected form ends the instruction with an error strobe and a code. Decoding then starts again on the same event.

Top module: `instr_byte_sequencer`

## Requirements
- R1: Event kinds are coded 0 none, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, 5 opcode fetch, 6 interrupt acknowledge. While idle, only a kind-5 event starts an instruction. Other kinds, and cycles with `ev_valid` low, change nothing and raise no strobe.
- R2: A fetched byte of 0xCB, 0xED, 0xDD or 0xFD is a prefix, and a later fetch that is itself a prefix byte (other than 0xCB) replaces it. After 0xDD or 0xFD, a fetched 0xCB forms the 16-bit prefix {first, 0xCB}, for example 0xFDCB. The next two memory reads are then taken as the displacement and the opcode. `f_prefix` holds 0 when no prefix was seen, otherwise the single prefix byte zero-extended or the 16-bit prefix.
- R3: While an opcode is pending, `attr_prefix`/`attr_opcode` present it and the attribute inputs decide the path. The count inputs mean: displacement 0–1, immediate 0–2, read 0–2, write 0–2.
- R4: A displacement byte appears on `f_disp` sign-extended to 16 bits, for example 0xFE becomes 0xFFFE.
- R5: A 16-bit immediate is little-endian: the first byte is bits 7:0. An 8-bit immediate is zero-extended.
- R6: Operand collection starts straight after the opcode only if the following event is a read (kind 1 or 3) for read operands, or a write (kind 2 or 4) for write operands. A 16-bit read operand is little-endian on `f_rdop`.
- R7: A 16-bit write operand on `f_wrop` is little-endian when `attr_wr_big` is 0. When it is 1, the first byte is bits 15:8.
- R8: With the repeat flag set, another read event after a read operand byte, or after a write operand byte of an instruction that also reads, collects one more operand pair. The operand outputs then show the newest bytes.
- R9: `instr_done` pulses for one cycle after the event that completes the opcode, displacement and immediate of a valid instruction. `f_prefix`, `f_opcode`, `f_disp` and `f_imm` update at that same edge and are held until the next completion.
- R10: A malformed sequence pulses `err_stb` with `err_code`: 1 when a prefix is not followed by a fetch, 2 when the displacement or opcode of a 0xCB-form is not a memory read (kind 1), 3 when the lookup misses. `err_code` is 0 whenever `err_stb` is low.
- R11: Reset returns the sequencer to idle and clears every output field and strobe, including in the middle of an instruction.
- R12: The event that ends an instruction is evaluated again as a possible start, so a fetch that follows the last byte begins the next instruction without a lost cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | A bus cycle finished this clock |
| ev_kind | input | 3 | Kind of the finished cycle (R1 coding) |
| ev_byte | input | 8 | Data byte of the finished cycle |
| attr_prefix | output | 16 | Prefix of the pending opcode, to the lookup table |
| attr_opcode | output | 8 | Pending opcode byte, to the lookup table |
| attr_hit | input | 1 | The table holds an entry for this prefix/opcode |
| attr_ndisp | input | 2 | Displacement bytes after the opcode |
| attr_nimm | input | 2 | Immediate bytes |
| attr_nrd | input | 2 | Read operand bytes |
| attr_nwr | input | 2 | Write operand bytes |
| attr_repeat | input | 1 | Operand transfers repeat |
| attr_wr_big | input | 1 | 16-bit write operand arrives high byte first |
| instr_done | output | 1 | Instruction fields just published |
| f_prefix | output | 16 | Prefix of the last completed instruction |
| f_opcode | output | 8 | Opcode of the last completed instruction |
| f_disp | output | 16 | Sign-extended displacement |
| f_imm | output | 16 | Immediate value |
| f_rdop | output | 16 | Latest read operand |
| f_wrop | output | 16 | Latest write operand |
| err_stb | output | 1 | Malformed sequence detected |
| err_code | output | 2 | Error cause (R10 coding) |

## Verification
A fixed event stream covers every instruction shape:
- bare opcodes
- 8- and 16-bit immediates
- one- and two-byte reads
- writes in both byte orders
- a trailing displacement
- the 0xCB form with a leading displacement
- prefix chains
- repeated transfers that loop through read-only and read/write paths

Each shape ends on a different state exit, so a wrong byte order, a wrong sign extension or a missed loop changes a specific field. The error cases break the stream at each checking state, and each of them gives its own code. Directed cases feed non-fetch kinds and idle cycles to an idle sequencer, and apply reset while a prefix is pending. These show whether a spurious start or leftover state survives.

// File: rtl/instr_byte_sequencer.sv
module instr_byte_sequencer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_valid,
  input  logic [2:0]  ev_kind,
  input  logic [7:0]  ev_byte,
  output logic [15:0] attr_prefix,
  output logic [7:0]  attr_opcode,
  input  logic        attr_hit,
  input  logic [1:0]  attr_ndisp,
  input  logic [1:0]  attr_nimm,
  input  logic [1:0]  attr_nrd,
  input  logic [1:0]  attr_nwr,
  input  logic        attr_repeat,
  input  logic        attr_wr_big,
  output logic        instr_done,
  output logic [15:0] f_prefix,
  output logic [7:0]  f_opcode,
  output logic [15:0] f_disp,
  output logic [15:0] f_imm,
  output logic [15:0] f_rdop,
  output logic [15:0] f_wrop,
  output logic        err_stb,
  output logic [1:0]  err_code
);

  localparam logic [7:0] PX_CB = 8'hCB;
  localparam logic [7:0] PX_ED = 8'hED;
  localparam logic [7:0] PX_DD = 8'hDD;
  localparam logic [7:0] PX_FD = 8'hFD;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE1, S_PRE2, S_PREDIS, S_OPC, S_POSTDIS,
    S_IMM1, S_IMM2, S_ROP1, S_ROP2, S_WOP1, S_WOP2, S_RESTART
  } phase_t;

  phase_t      st, nxt, st_nx, tail;
  logic [7:0]  held, w_disp, w_imm_lo, w_op;
  logic [15:0] w_pfx;
  logic [1:0]  n_imm, n_rd, n_wr, err_c;
  logic        rep, big, done_c;

  wire is_fetch = ev_kind == 3'd5;
  wire is_mrd   = ev_kind == 3'd1;
  wire is_rd    = ev_kind == 3'd1 || ev_kind == 3'd3;
  wire is_wr    = ev_kind == 3'd2 || ev_kind == 3'd4;
  wire cur_pre  = ev_byte == PX_CB || ev_byte == PX_ED || ev_byte == PX_DD || ev_byte == PX_FD;
  wire cur_chain = ev_byte == PX_ED || ev_byte == PX_DD || ev_byte == PX_FD;
  wire held_ix  = held == PX_DD || held == PX_FD;
  wire restart  = nxt == S_RESTART;
  wire start    = restart && is_fetch;

  assign attr_prefix = w_pfx;
  assign attr_opcode = held;
  assign tail = (n_rd != 2'd0) ? S_ROP1 : (n_wr != 2'd0) ? S_WOP1 : S_RESTART;

  always_comb begin
    nxt    = S_RESTART;
    err_c  = 2'd0;
    done_c = 1'b0;
    case (st)
      S_PRE1:
        if (!is_fetch) err_c = 2'd1;
        else if (held_ix && ev_byte == PX_CB) nxt = S_PRE2;
        else if (cur_chain) nxt = S_PRE1;
        else nxt = S_OPC;
      S_PRE2:
        if (!is_mrd) err_c = 2'd2;
        else nxt = S_PREDIS;
      S_PREDIS:
        if (!is_mrd) err_c = 2'd2;
        else nxt = S_OPC;
      S_OPC:
        if (!attr_hit) err_c = 2'd3;
        else if (attr_ndisp != 2'd0) nxt = S_POSTDIS;
        else if (attr_nimm != 2'd0) nxt = S_IMM1;
        else begin
          done_c = 1'b1;
          if (attr_nrd != 2'd0 && is_rd) nxt = S_ROP1;
          else if (attr_nwr != 2'd0 && is_wr) nxt = S_WOP1;
        end
      S_POSTDIS:
        if (n_imm != 2'd0) nxt = S_IMM1;
        else begin done_c = 1'b1; nxt = tail; end
      S_IMM1:
        if (n_imm > 2'd1) nxt = S_IMM2;
        else begin done_c = 1'b1; nxt = tail; end
      S_IMM2: begin done_c = 1'b1; nxt = tail; end
      S_ROP1:
        if (n_wr != 2'd0) nxt = S_WOP1;
        else if (n_rd > 2'd1) nxt = S_ROP2;
        else if (rep && is_rd) nxt = S_ROP1;
      S_ROP2:
        if (n_wr != 2'd0) nxt = S_WOP1;
      S_WOP1:
        if (n_rd > 2'd1) nxt = S_ROP2;
        else if (n_wr > 2'd1) nxt = S_WOP2;
        else if (n_rd != 2'd0 && rep && is_rd) nxt = S_ROP1;
      default: nxt = S_RESTART;
    endcase
    if (restart) st_nx = is_fetch ? (cur_pre ? S_PRE1 : S_OPC) : S_IDLE;
    else st_nx = nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      held <= '0; w_pfx <= '0; w_disp <= '0; w_imm_lo <= '0; w_op <= '0;
      n_imm <= '0; n_rd <= '0; n_wr <= '0; rep <= 1'b0; big <= 1'b0;
      instr_done <= 1'b0; err_stb <= 1'b0; err_code <= '0;
      f_prefix <= '0; f_opcode <= '0; f_disp <= '0; f_imm <= '0;
      f_rdop <= '0; f_wrop <= '0;
    end else if (ev_valid) begin
      st <= st_nx;
      held <= ev_byte;
      instr_done <= done_c;
      err_stb <= err_c != 2'd0;
      err_code <= err_c;
      case (st)
        S_PRE1:   if (is_fetch) w_pfx <= {8'h00, held};
        S_PRE2:   if (is_mrd) w_pfx <= {w_pfx[7:0], held};
        S_PREDIS: if (is_mrd) w_disp <= held;
        S_OPC: begin
          w_op <= held;
          n_imm <= attr_nimm; n_rd <= attr_nrd; n_wr <= attr_nwr;
          rep <= attr_repeat; big <= attr_wr_big;
          if (done_c) begin
            f_prefix <= w_pfx; f_opcode <= held;
            f_disp <= {{8{w_disp[7]}}, w_disp}; f_imm <= '0;
          end
        end
        S_POSTDIS: begin
          w_disp <= held;
          if (done_c) begin
            f_prefix <= w_pfx; f_opcode <= w_op;
            f_disp <= {{8{held[7]}}, held}; f_imm <= '0;
          end
        end
        S_IMM1: begin
          w_imm_lo <= held;
          if (done_c) begin
            f_prefix <= w_pfx; f_opcode <= w_op;
            f_disp <= {{8{w_disp[7]}}, w_disp}; f_imm <= {8'h00, held};
          end
        end
        S_IMM2: begin
          f_prefix <= w_pfx; f_opcode <= w_op;
          f_disp <= {{8{w_disp[7]}}, w_disp}; f_imm <= {held, w_imm_lo};
        end
        S_ROP1: f_rdop <= {8'h00, held};
        S_ROP2: f_rdop <= {held, f_rdop[7:0]};
        S_WOP1: f_wrop <= {8'h00, held};
        S_WOP2: f_wrop <= big ? {f_wrop[7:0], held} : {held, f_wrop[7:0]};
        default: ;
      endcase
      if (start) begin
        w_pfx <= '0;
        w_disp <= '0;
        w_imm_lo <= '0;
      end
    end else begin
      instr_done <= 1'b0;
      err_stb <= 1'b0;
      err_code <= '0;
    end
  end

endmodule

module instr_byte_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_valid,
  input logic        instr_done,
  input logic        err_stb,
  input logic [1:0]  err_code,
  input logic [15:0] f_disp
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> (!instr_done && !err_stb));

  assert_disp_sext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    f_disp[15:8] == {8{f_disp[7]}});

  assert_done_needs_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> $past(ev_valid));

  assert_done_excl_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> !err_stb);

  assert_code_with_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_stb |-> err_code != 2'd0);

  assert_code_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !err_stb |-> err_code == 2'd0);

endmodule

bind instr_byte_sequencer instr_byte_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .instr_done(instr_done),
  .err_stb(err_stb), .err_code(err_code), .f_disp(f_disp)
);

// File: tb/instr_byte_sequencer_tb.sv
`timescale 1ns/1ps
module instr_byte_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [2:0]  ev_kind = '0;
  logic [7:0]  ev_byte = '0;
  logic [15:0] attr_prefix;
  logic [7:0]  attr_opcode;
  logic        attr_hit, attr_repeat, attr_wr_big;
  logic [1:0]  attr_ndisp, attr_nimm, attr_nrd, attr_nwr;
  logic        instr_done, err_stb;
  logic [1:0]  err_code;
  logic [15:0] f_prefix, f_disp, f_imm, f_rdop, f_wrop;
  logic [7:0]  f_opcode;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  instr_byte_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte),
    .attr_prefix(attr_prefix), .attr_opcode(attr_opcode), .attr_hit(attr_hit),
    .attr_ndisp(attr_ndisp), .attr_nimm(attr_nimm), .attr_nrd(attr_nrd), .attr_nwr(attr_nwr),
    .attr_repeat(attr_repeat), .attr_wr_big(attr_wr_big), .instr_done(instr_done),
    .f_prefix(f_prefix), .f_opcode(f_opcode), .f_disp(f_disp), .f_imm(f_imm),
    .f_rdop(f_rdop), .f_wrop(f_wrop), .err_stb(err_stb), .err_code(err_code)
  );

  // stub table, R3: {hit, disp, imm, rd, wr, repeat, big}
  function automatic logic [10:0] lut(input logic [15:0] p, input logic [7:0] o);
    case ({p, o})
      24'h000000: lut = {1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0};
      24'h00003E: lut = {1'b1, 2'd0, 2'd1, 2'd0, 2'd0, 1'b0, 1'b0};
      24'h000021: lut = {1'b1, 2'd0, 2'd2, 2'd0, 2'd0, 1'b0, 1'b0};
      24'h00007E: lut = {1'b1, 2'd0, 2'd0, 2'd1, 2'd0, 1'b0, 1'b0};
      24'h000077: lut = {1'b1, 2'd0, 2'd0, 2'd0, 2'd1, 1'b0, 1'b0};
      24'h0000C5: lut = {1'b1, 2'd0, 2'd0, 2'd0, 2'd2, 1'b0, 1'b1};
      24'h00002A: lut = {1'b1, 2'd0, 2'd2, 2'd2, 2'd0, 1'b0, 1'b0};
      24'h000022: lut = {1'b1, 2'd0, 2'd2, 2'd0, 2'd2, 1'b0, 1'b0};
      24'h00DD7E: lut = {1'b1, 2'd1, 2'd0, 2'd1, 2'd0, 1'b0, 1'b0};
      24'h00FD36: lut = {1'b1, 2'd1, 2'd1, 2'd0, 2'd1, 1'b0, 1'b0};
      24'hDDCB06: lut = {1'b1, 2'd0, 2'd0, 2'd1, 2'd1, 1'b0, 1'b0};
      24'hFDCB06: lut = {1'b1, 2'd0, 2'd0, 2'd1, 2'd1, 1'b0, 1'b0};
      24'h00EDB0: lut = {1'b1, 2'd0, 2'd0, 2'd1, 2'd1, 1'b1, 1'b0};
      24'h00EDB1: lut = {1'b1, 2'd0, 2'd0, 2'd1, 2'd0, 1'b1, 1'b0};
      default:    lut = '0;
    endcase
  endfunction

  assign {attr_hit, attr_ndisp, attr_nimm, attr_nrd, attr_nwr, attr_repeat, attr_wr_big} =
    lut(attr_prefix, attr_opcode);

  localparam logic [2:0] R = 3'd1, W = 3'd2, F = 3'd5, IA = 3'd6;
  localparam logic [2:0] NONE = 3'd0, OPC = 3'd1, PFX = 3'd2, DSP = 3'd3, IMM = 3'd4, ROP = 3'd5, WOP = 3'd6;

  // {kind, byte, done, err, field, value}
  localparam logic [32:0] VEC [63] = '{
    {F, 8'h00, 1'b0, 2'd0, NONE, 16'h0000},
    {F, 8'h3E, 1'b1, 2'd0, OPC,  16'h0000}, // R12 ending fetch restarts
    {R, 8'h55, 1'b0, 2'd0, NONE, 16'h0000},
    {F, 8'h21, 1'b1, 2'd0, IMM,  16'h0055},
    {R, 8'h34, 1'b0, 2'd0, NONE, 16'h0000},
    {R, 8'h12, 1'b0, 2'd0, NONE, 16'h0000},
    {F, 8'h7E, 1'b1, 2'd0, IMM,  16'h1234},
    {R, 8'hA5, 1'b1, 2'd0, OPC,  16'h007E},
    {F, 8'h77, 1'b0, 2'd0, ROP,  16'h00A5},
    {W, 8'h3C, 1'b1, 2'd0, OPC,  16'h0077},
    {F, 8'hC5, 1'b0, 2'd0, WOP,  16'h003C},
    {W, 8'hAB, 1'b1, 2'd0, NONE, 16'h0000},
    {W, 8'hCD, 1'b0, 2'd0, NONE, 16'h0000},
    {F, 8'h2A, 1'b0, 2'd0, WOP,  16'hABCD},
    {R, 8'h00, 1'b0, 2'd0, NONE, 16'h0000},
    {R, 8'h40, 1'b0, 2'd0, NONE, 16'h0000},
    {R, 8'h9A, 1'b1, 2'd0, IMM,  16'h4000},
    {R, 8'h78, 1'b0, 2'd0, NONE, 16'h0000},
    {F, 8'h22, 1'b0, 2'd0, ROP,  16'h789A},
    {R, 8'h10, 1'b0, 2'd0, NONE, 16'h0000},
    {R, 8'h20, 1'b0, 2'd0, NONE, 16'h0000},
    {W, 8'h5A, 1'b1, 2'd0, IMM,  16'h2010},
    {W, 8'hA5, 1'b0, 2'd0, NONE, 16'h0000},
    {F, 8'hDD, 1'b0, 2'd0, WOP,  16'hA55A},
    {F, 8'h7E, 1'b0, 2'd0, NONE, 16'h0000},
    {R, 8'hFE, 1'b0, 2'd0, NONE, 16'h0000},
    {R, 8'h42, 1'b1, 2'd0, DSP,  16'hFFFE},
    {F, 8'hFD, 1'b0, 2'd0, ROP,  16'h0042},
    {F, 8'hCB, 1'b0, 2'd0, NONE, 16'h0000},
    {R, 8'h05, 1'b0, 2'd0, NONE, 16'h0000},
    {R, 8'h06, 1'b0, 2'd0, NONE, 16'h0000},
    {R, 8'h77, 1'b1, 2'd0, PFX,  16'hFDCB},
    {W, 8'h88, 1'b0, 2'd0, NONE, 16'h0000},
    {F, 8'hED, 1'b0, 2'd0, WOP,  16'h0088},
    {F, 8'hB0, 1'b0, 2'd0, NONE, 16'h0000},
    {R, 8'h01, 1'b1, 2'd0, PFX,  16'h00ED},
    {W, 8'h01, 1'b0, 2'd0, NONE, 16'h0000},
    {R, 8'h02, 1'b0, 2'd0, NONE, 16'h0000}, // R8 write byte loops back to read
    {W, 8'h02, 1'b0, 2'd0, ROP,  16'h0002},
    {F, 8'hED, 1'b0, 2'd0, WOP,  16'h0002},
    {F, 8'hB1, 1'b0, 2'd0, NONE, 16'h0000},
    {R, 8'h0A, 1'b1, 2'd0, OPC,  16'h00B1},
    {R, 8'h0B, 1'b0, 2'd0, NONE, 16'h0000},
    {R, 8'h0C, 1'b0, 2'd0, ROP,  16'h000B}, // R8 read-only repeat stays
    {F, 8'hED, 1'b0, 2'd0, ROP,  16'h000C},
    {R, 8'h00, 1'b0, 2'd1, NONE, 16'h0000},
    {F, 8'hDD, 1'b0, 2'd0, NONE, 16'h0000},
    {F, 8'hCB, 1'b0, 2'd0, NONE, 16'h0000},
    {F, 8'hFD, 1'b0, 2'd2, NONE, 16'h0000},
    {F, 8'hCB, 1'b0, 2'd0, NONE, 16'h0000},
    {R, 8'h03, 1'b0, 2'd0, NONE, 16'h0000},
    {F, 8'hED, 1'b0, 2'd2, NONE, 16'h0000},
    {F, 8'h00, 1'b0, 2'd0, NONE, 16'h0000},
    {F, 8'h00, 1'b0, 2'd3, NONE, 16'h0000}, // R3 lookup miss
    {R, 8'h00, 1'b1, 2'd0, OPC,  16'h0000},
    {W, 8'h12, 1'b0, 2'd0, NONE, 16'h0000},
    {F, 8'hDD, 1'b0, 2'd0, NONE, 16'h0000},
    {F, 8'hFD, 1'b0, 2'd0, NONE, 16'h0000},
    {F, 8'h36, 1'b0, 2'd0, NONE, 16'h0000},
    {R, 8'hF0, 1'b0, 2'd0, NONE, 16'h0000},
    {R, 8'h99, 1'b0, 2'd0, NONE, 16'h0000},
    {W, 8'h77, 1'b1, 2'd0, PFX,  16'h00FD},
    {F, 8'h00, 1'b0, 2'd0, WOP,  16'h0077}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ev(input logic [2:0] k, input logic [7:0] b);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_byte = b;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  function automatic string tag_of(input logic [2:0] sel);
    case (sel)
      OPC: tag_of = "R9 opcode";
      PFX: tag_of = "R2 prefix";
      DSP: tag_of = "R4 disp";
      IMM: tag_of = "R5 imm";
      ROP: tag_of = "R6 rdop";
      default: tag_of = "R7 wrop";
    endcase
  endfunction

  function automatic logic [15:0] field_of(input logic [2:0] sel);
    case (sel)
      OPC: field_of = {8'h00, f_opcode};
      PFX: field_of = f_prefix;
      DSP: field_of = f_disp;
      IMM: field_of = f_imm;
      ROP: field_of = f_rdop;
      default: field_of = f_wrop;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset strobes", {13'd0, instr_done, err_code}, 16'h0000);
    check("R11 reset fields", f_prefix | f_disp | f_imm | f_rdop | f_wrop | {8'h00, f_opcode}, 16'h0000);

    ev(IA, 8'h00);
    ev(R, 8'h00);
    check("R1 interrupt ack does not start", {13'd0, instr_done, err_code}, 16'h0000);
    ev_kind = F; ev_byte = 8'h00;
    repeat (4) @(negedge clk);
    ev(R, 8'h00);
    check("R1 invalid cycles ignored", {13'd0, instr_done, err_code}, 16'h0000);

    for (int i = 0; i < 63; i++) begin
      ev(VEC[i][32:30], VEC[i][29:22]);
      check("R9 R10 strobe", {13'd0, instr_done, err_code}, {13'd0, VEC[i][21:19]});
      if (VEC[i][18:16] != NONE)
        check(tag_of(VEC[i][18:16]), field_of(VEC[i][18:16]), VEC[i][15:0]);
    end

    ev(F, 8'hDD);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    ev(R, 8'h00);
    check("R11 reset drops pending prefix", {13'd0, instr_done, err_code}, 16'h0000);
    check("R11 reset clears write operand", f_wrop, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule